// File: doc/BRIEF.md
# External interrupt sense and sleep control

This block holds one byte-wide control register that decides how an asynchronous external interrupt pin turns into a request to the core, and how the core's sleep instruction becomes a sleep entry request. The pin first passes through a synchronizer. It is then judged against the selected sense code: a low level, a falling edge or a rising edge. One code is reserved and never produces a request.

In the two edge modes, a detected edge sets a sticky pending flag. The flag is set even while interrupts are masked. It is cleared by the core's accept pulse, or by a register write that changes the sense code. In low-level mode nothing is latched. The request simply follows the synchronized pin.

The request leaves the block only when both the global interrupt enable and this source's mask bit are set. A one-cycle sleep strobe from the core turns into a one-cycle idle or power-down request, but only when the sleep enable bit is set.

Top module: `ext_irq_sleep_ctrl`

## Requirements
- R1: Register bit 5 is sleep enable, bit 4 is sleep mode select (0 idle, 1 power-down), and bits 1:0 are the sense code. Bits 7, 6, 3 and 2 ignore writes and always read zero. A write shows on the read port one cycle later.
- R2: After reset the register reads 0x00 and all three outputs (irq, idle, power-down) are low.
- R3: Sense code 01 is reserved. While it is selected, neither a low level nor any edge on the pin produces a request.
- R4: With sense code 00, the request is high two cycles after the pin goes low. It stays high while the pin stays low, and drops two cycles after the pin returns high, with no latching.
- R5: The request output is low whenever the global enable or the source mask is low, in every sense mode.
- R6: With sense code 10 (falling edge) or 11 (rising edge), a matching edge held for at least two cycles sets a pending flag three cycles after the pin changes. The flag stays set after the pin returns, and is set even while the request is gated off, so raising the enables later shows the request at once.
- R7: A pending flag clears one cycle after an accept pulse, or after a register write that changes the sense code. A write that keeps the same code leaves the flag alone. A new edge detected in the same cycle as the accept keeps the flag set.
- R8: A sleep strobe while sleep enable is 0 produces no idle or power-down pulse.
- R9: A sleep strobe while sleep enable is 1 produces a one-cycle pulse one cycle later: on idle when the mode select is 0, on power-down when it is 1. Never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| pin_i | input | 1 | Raw asynchronous interrupt pin |
| gie_i | input | 1 | Global interrupt enable |
| mask_i | input | 1 | Mask bit for this source |
| irq_ack_i | input | 1 | Interrupt accepted pulse from the core |
| sleep_cmd_i | input | 1 | One-cycle sleep instruction strobe |
| irq_o | output | 1 | Gated interrupt request |
| idle_req_o | output | 1 | Idle-mode entry pulse |
| pdown_req_o | output | 1 | Power-down entry pulse |

## Verification
The properties assume that the sleep strobe and the accept pulse are single-cycle events driven synchronously to the clock. They also assume the pin is the only asynchronous input. The stimulus keeps every pin level for at least two clock periods, so no edge falls into the region where catching it is not guaranteed. Strobes and accepts are driven for exactly one cycle, shortly after a falling clock edge. One case deliberately places an accept in the same cycle as a fresh edge detection, to exercise the set-over-clear priority.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned BIT_SLEEP_EN   = 5;
  localparam int unsigned BIT_SLEEP_MODE = 4;
  localparam int unsigned BIT_SENSE_LO   = 0;
  localparam int unsigned SENSE_W        = 2;

  localparam logic [REG_W-1:0] WRITE_MASK = 8'h33;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_ctrl_reg.sv
module eis_ctrl_reg
  import ext_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             sleep_en_o,
  output logic             sleep_mode_o,
  output sense_e           sense_o,
  output logic             sense_chg_o
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_d;

  assign reg_d = wdata_i & WRITE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (we_i) reg_q <= reg_d;
  end

  assign rdata_o      = reg_q;
  assign sleep_en_o   = reg_q[BIT_SLEEP_EN];
  assign sleep_mode_o = reg_q[BIT_SLEEP_MODE];
  assign sense_o      = sense_e'(reg_q[BIT_SENSE_LO +: SENSE_W]);
  // only a change of code discards a pending edge
  assign sense_chg_o  = we_i &&
                        (reg_d[BIT_SENSE_LO +: SENSE_W] != reg_q[BIT_SENSE_LO +: SENSE_W]);
endmodule

// File: rtl/eis_pin_sync.sv
module eis_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PIN_IDLE    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_s_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= PIN_IDLE;
        else         sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= {SYNC_STAGES{PIN_IDLE}};
        else         sync_q <= {sync_q[MSB-1:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= PIN_IDLE;
    else         prev_q <= sync_q[MSB];
  end

  assign pin_s_o = sync_q[MSB];
  assign rise_o  = sync_q[MSB] & ~prev_q;
  assign fall_o  = ~sync_q[MSB] & prev_q;
endmodule

// File: rtl/eis_irq_sense.sv
module eis_irq_sense
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  sense_e sense_i,
  input  logic   sense_chg_i,
  input  logic   pin_s_i,
  input  logic   rise_i,
  input  logic   fall_i,
  input  logic   gie_i,
  input  logic   mask_i,
  input  logic   ack_i,
  output logic   edge_hit_o,
  output logic   pending_o,
  output logic   irq_o
);
  logic pending_q;
  logic raw_req;

  always_comb begin
    unique case (sense_i)
      SENSE_FALL: edge_hit_o = fall_i;
      SENSE_RISE: edge_hit_o = rise_i;
      default:    edge_hit_o = 1'b0;
    endcase
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pending_q <= 1'b0;
    else if (edge_hit_o)               pending_q <= 1'b1;
    else if (ack_i || sense_chg_i)     pending_q <= 1'b0;
  end

  always_comb begin
    unique case (sense_i)
      SENSE_LOW:  raw_req = ~pin_s_i;
      SENSE_RSVD: raw_req = 1'b0;
      default:    raw_req = pending_q;
    endcase
  end

  assign pending_o = pending_q;
  assign irq_o     = gie_i & mask_i & raw_req;
endmodule

// File: rtl/eis_sleep_ctrl.sv
module eis_sleep_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic en_i,
  input  logic mode_i,
  output logic idle_o,
  output logic pdown_o
);
  logic go;

  assign go = cmd_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_o  <= 1'b0;
      pdown_o <= 1'b0;
    end else begin
      idle_o  <= go & ~mode_i;
      pdown_o <= go &  mode_i;
    end
  end
endmodule

// File: rtl/ext_irq_sleep_ctrl.sv
module ext_irq_sleep_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PIN_IDLE    = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       pin_i,
  input  logic       gie_i,
  input  logic       mask_i,
  input  logic       irq_ack_i,
  input  logic       sleep_cmd_i,
  output logic       irq_o,
  output logic       idle_req_o,
  output logic       pdown_req_o
);
  logic   sleep_en;
  logic   sleep_mode;
  sense_e sense;
  logic   sense_chg;
  logic   pin_s;
  logic   pin_rise;
  logic   pin_fall;
  logic   edge_hit;
  logic   pending;

  eis_ctrl_reg i_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .sleep_en_o   (sleep_en),
    .sleep_mode_o (sleep_mode),
    .sense_o      (sense),
    .sense_chg_o  (sense_chg)
  );

  eis_pin_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .PIN_IDLE    (PIN_IDLE)
  ) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .pin_s_o (pin_s),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  eis_irq_sense i_sense (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sense_i     (sense),
    .sense_chg_i (sense_chg),
    .pin_s_i     (pin_s),
    .rise_i      (pin_rise),
    .fall_i      (pin_fall),
    .gie_i       (gie_i),
    .mask_i      (mask_i),
    .ack_i       (irq_ack_i),
    .edge_hit_o  (edge_hit),
    .pending_o   (pending),
    .irq_o       (irq_o)
  );

  eis_sleep_ctrl i_sleep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (sleep_cmd_i),
    .en_i    (sleep_en),
    .mode_i  (sleep_mode),
    .idle_o  (idle_req_o),
    .pdown_o (pdown_req_o)
  );
endmodule

// File: rtl/eis_checker.sv
module eis_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] reg_rdata_o,
  input logic       gie_i,
  input logic       mask_i,
  input logic       irq_ack_i,
  input logic       sleep_cmd_i,
  input logic       irq_o,
  input logic       idle_req_o,
  input logic       pdown_req_o,
  input logic       pin_s,
  input logic       sense_chg,
  input logic       edge_hit,
  input logic       pending
);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & 8'hCC) == 8'h00);

  assert_rsvd_code_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1:0] == 2'b01) |-> !irq_o);

  assert_level_follows_pin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1:0] == 2'b00 && gie_i && mask_i) |-> (irq_o == !pin_s));

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && mask_i));

  assert_pending_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && !irq_ack_i && !sense_chg) |=> pending);

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !edge_hit) |=> !pending);

  assert_edge_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit |=> pending);

  assert_sleep_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_req_o || pdown_req_o) |-> ($past(sleep_cmd_i) && $past(reg_rdata_o[5])));

  assert_sleep_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idle_req_o, pdown_req_o}));
endmodule

bind ext_irq_sleep_ctrl eis_checker i_eis_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rdata_o (reg_rdata_o),
  .gie_i       (gie_i),
  .mask_i      (mask_i),
  .irq_ack_i   (irq_ack_i),
  .sleep_cmd_i (sleep_cmd_i),
  .irq_o       (irq_o),
  .idle_req_o  (idle_req_o),
  .pdown_req_o (pdown_req_o),
  .pin_s       (pin_s),
  .sense_chg   (sense_chg),
  .edge_hit    (edge_hit),
  .pending     (pending)
);

// File: tb/test_ext_irq_sleep_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_sleep_ctrl;
  localparam int SEL_IRQ = 0, SEL_IDLE = 1, SEL_PDN = 2, SEL_RD = 3;

  typedef struct {
    int          cyc;
    int          sel;
    logic [7:0]  val;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pin = 1'b1;
  logic       gie = 1'b0;
  logic       mask = 1'b0;
  logic       ack = 1'b0;
  logic       sleep_cmd = 1'b0;
  logic       irq, idle_req, pdown_req;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_irq_sleep_ctrl i_ext_irq_sleep_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (reg_we),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .pin_i       (pin),
    .gie_i       (gie),
    .mask_i      (mask),
    .irq_ack_i   (irq_ack_i_w),
    .sleep_cmd_i (sleep_cmd),
    .irq_o       (irq),
    .idle_req_o  (idle_req),
    .pdown_req_o (pdown_req)
  );

  logic irq_ack_i_w;
  assign irq_ack_i_w = ack;

  // monitor: pops scoreboard items due at this sample point
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      logic [7:0] act;
      e = sb.pop_front();
      case (e.sel)
        SEL_IRQ:  act = {7'd0, irq};
        SEL_IDLE: act = {7'd0, idle_req};
        SEL_PDN:  act = {7'd0, pdown_req};
        default:  act = reg_rdata;
      endcase
      checks++;
      if (e.cyc != cyc || act !== e.val) begin
        failures++;
        $display("FAIL %s sel=%0d cyc=%0d actual=%02h expected=%02h", e.req, e.sel, cyc, act, e.val);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_at(int d, int sel, logic [7:0] v, string r);
    exp_t e;
    e.cyc = cyc + d;
    e.sel = sel;
    e.val = v;
    e.req = r;
    sb.push_back(e);
  endtask

  task automatic wr(logic [7:0] v, string r);
    reg_we = 1'b1;
    reg_wdata = v;
    expect_at(1, SEL_RD, v & 8'h33, r);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic drain();
    tick(6);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    tick(2);
    // R2 reset state
    expect_at(1, SEL_RD, 8'h00, "R2");
    expect_at(1, SEL_IRQ, 8'h00, "R2");
    expect_at(1, SEL_IDLE, 8'h00, "R2");
    expect_at(1, SEL_PDN, 8'h00, "R2");
    tick(2);
    rst_n = 1'b1;
    tick(2);

    // R1 reserved bits read zero
    wr(8'hFF, "R1");
    wr(8'hCC, "R1");
    drain();

    // R4 level mode tracks pin
    wr(8'h00, "R1");
    gie = 1'b1; mask = 1'b1;
    tick(3);
    pin = 1'b0;
    expect_at(1, SEL_IRQ, 8'h00, "R4");
    expect_at(2, SEL_IRQ, 8'h01, "R4");
    expect_at(5, SEL_IRQ, 8'h01, "R4");
    tick(5);
    pin = 1'b1;
    expect_at(1, SEL_IRQ, 8'h01, "R4");
    expect_at(2, SEL_IRQ, 8'h00, "R4");
    drain();

    // R5 gating in level mode
    pin = 1'b0; gie = 1'b0;
    expect_at(3, SEL_IRQ, 8'h00, "R5");
    tick(4);
    gie = 1'b1; mask = 1'b0;
    expect_at(2, SEL_IRQ, 8'h00, "R5");
    tick(3);
    mask = 1'b1;
    pin = 1'b1;
    drain();

    // R3 reserved code: no request on level or edges
    wr(8'h01, "R3");
    pin = 1'b0;
    expect_at(3, SEL_IRQ, 8'h00, "R3");
    tick(4);
    pin = 1'b1;
    expect_at(3, SEL_IRQ, 8'h00, "R3");
    drain();

    // R6 falling edge sets sticky pending
    wr(8'h02, "R1");
    pin = 1'b0;
    expect_at(2, SEL_IRQ, 8'h00, "R6");
    expect_at(3, SEL_IRQ, 8'h01, "R6");
    tick(2);
    pin = 1'b1;
    expect_at(4, SEL_IRQ, 8'h01, "R6");
    tick(5);
    // R7 accept clears
    ack = 1'b1;
    expect_at(1, SEL_IRQ, 8'h00, "R7");
    tick();
    ack = 1'b0;
    drain();

    // R6 rising mode ignores falling, catches rising
    wr(8'h03, "R1");
    pin = 1'b0;
    expect_at(3, SEL_IRQ, 8'h00, "R6");
    tick(4);
    pin = 1'b1;
    expect_at(3, SEL_IRQ, 8'h01, "R6");
    tick(4);
    // R7 same-code write keeps, changed code clears
    wr(8'h33, "R7");
    expect_at(1, SEL_IRQ, 8'h01, "R7");
    tick(2);
    expect_at(1, SEL_IRQ, 8'h00, "R7");
    wr(8'h02, "R7");
    drain();

    // R6 edge while masked is serviced later
    gie = 1'b0;
    pin = 1'b0;
    expect_at(4, SEL_IRQ, 8'h00, "R5");
    tick(5);
    pin = 1'b1;
    gie = 1'b1;
    expect_at(1, SEL_IRQ, 8'h01, "R6");
    tick(2);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    drain();

    // R7 edge coincident with accept keeps flag set
    wr(8'h03, "R1");
    pin = 1'b0; tick(3);
    pin = 1'b1;
    expect_at(3, SEL_IRQ, 8'h01, "R7");
    tick(4);
    pin = 1'b0; tick(3);
    pin = 1'b1;
    expect_at(3, SEL_IRQ, 8'h01, "R7");
    expect_at(4, SEL_IRQ, 8'h01, "R7");
    tick(2);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    tick(3);
    ack = 1'b1;
    expect_at(1, SEL_IRQ, 8'h00, "R7");
    tick();
    ack = 1'b0;
    drain();

    // R8 sleep strobe ignored when disabled
    wr(8'h10, "R1");
    sleep_cmd = 1'b1;
    expect_at(1, SEL_IDLE, 8'h00, "R8");
    expect_at(1, SEL_PDN, 8'h00, "R8");
    tick();
    sleep_cmd = 1'b0;
    drain();

    // R9 idle pulse
    wr(8'h20, "R1");
    sleep_cmd = 1'b1;
    expect_at(1, SEL_IDLE, 8'h01, "R9");
    expect_at(1, SEL_PDN, 8'h00, "R9");
    expect_at(2, SEL_IDLE, 8'h00, "R9");
    tick();
    sleep_cmd = 1'b0;
    drain();

    // R9 power-down pulse
    wr(8'h30, "R1");
    sleep_cmd = 1'b1;
    expect_at(1, SEL_PDN, 8'h01, "R9");
    expect_at(1, SEL_IDLE, 8'h00, "R9");
    expect_at(2, SEL_PDN, 8'h00, "R9");
    tick();
    sleep_cmd = 1'b0;
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule